// File: doc/BRIEF.md
# Operand Address Generator

This unit sits between the instruction decoder and the data-side memories of an 8-bit accumulator-style microcontroller. For each request it takes the decoded addressing mode and the instruction fields, and reads the register state the mode needs: bank-select bits, the R0/R1 contents, the data pointer, the program counter and the accumulator. From these it forms one effective operand address. Alongside the address it gives a tag naming the memory space the access goes to.

The unit also owns the stack pointer. A push or pop strobe moves the pointer by one and yields the stack slot as the operand address. All outputs are registered, so a request presented before a rising edge shows its result after that edge.

The address output is 16 bits wide. Modes that form an 8-bit internal address put it in the low byte and drive the high byte to zero.

Top module: `opaddr_gen`

## Requirements
- R1: While reset is asserted and directly after it, `valid_o` is 0 and `sp_o` is 07H.
- R2: Mode 0 (direct) gives `addr_o = dir_addr`. The space is internal RAM (code 0) for 00H–7FH and the special-register space (code 1) for 80H–FFH.
- R3: Mode 1 (register) gives `addr_o = {bank_sel, reg_sel}`, which lies in 00H–1FH, with space code 0.
- R4: Mode 2 (pointer-register indirect) gives the contents of R0 when `reg_sel[0]` is 0 and of R1 when it is 1. The space is code 0 even for 80H–FFH, which is upper internal RAM.
- R5: Mode 3 (stack indirect) gives the current `sp_o` with space code 0 and leaves the stack pointer unchanged.
- R6: Mode 4 (external data) gives `addr_o = dptr` with space code 2.
- R7: Mode 5 (table index) gives `(dptr + acc) mod 65536`, with the accumulator taken as unsigned, and space code 3.
- R8: Mode 6 (relative index) gives `(pc + acc) mod 65536` with space code 3.
- R9: A push alone increments the stack pointer modulo 256. The output address is the incremented value, tagged with space code 0.
- R10: A pop alone outputs the current stack pointer as the address, tagged with space code 0, and then decrements the pointer modulo 256.
- R11: A push or pop overrides any request mode presented in the same cycle. When push and pop are asserted together, neither acts: the stack pointer holds and the request is served as normal.
- R12: `valid_o` is 0 in the cycle after any cycle that has no push, no pop, and either `req` low or mode 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Operand request strobe |
| mode | input | 3 | Addressing mode code (0–7) |
| reg_sel | input | 3 | Register number from the opcode |
| dir_addr | input | 8 | Direct address byte |
| bank_sel | input | 2 | Register bank select bits |
| r0_val | input | 8 | R0 contents of the current bank |
| r1_val | input | 8 | R1 contents of the current bank |
| dptr | input | 16 | Data pointer |
| pc | input | 16 | Program counter |
| acc | input | 8 | Accumulator |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| addr_o | output | 16 | Effective operand address |
| space_o | output | 2 | Space tag: 0 internal RAM, 1 special registers, 2 external RAM, 3 program memory |
| valid_o | output | 1 | Address and space are valid |
| sp_o | output | 8 | Current stack pointer |

## Verification
The bench builds the unit with its default parameters: 8-bit internal addresses, 16-bit wide addresses, 2 bank bits, 3 register bits and a stack pointer that resets to 07H. With a reset value this low, eight pops take the pointer down through 00H to FFH, and one push then takes it back to 00H, so both wrap-arounds cost only a handful of cycles. The 16-bit index sums are driven with operands near FFFFH so that their carry out is dropped.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam int OA_IA_W = 8;
  localparam int OA_WA_W = 16;

  typedef enum logic [2:0] {
    MD_DIRECT  = 3'd0,
    MD_REG     = 3'd1,
    MD_IND_PTR = 3'd2,
    MD_IND_SP  = 3'd3,
    MD_XDATA   = 3'd4,
    MD_IDX_DP  = 3'd5,
    MD_IDX_PC  = 3'd6,
    MD_NONE    = 3'd7
  } oa_mode_e;

  typedef enum logic [1:0] {
    SPC_IRAM = 2'd0,
    SPC_SFR  = 2'd1,
    SPC_XRAM = 2'd2,
    SPC_CODE = 2'd3
  } oa_space_e;

endpackage

// File: rtl/opaddr_bank_map.sv
module opaddr_bank_map #(
  parameter int IA_W   = 8,
  parameter int RSEL_W = 3,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [RSEL_W-1:0] reg_sel,
  input  logic [IA_W-1:0]   r0_val,
  input  logic [IA_W-1:0]   r1_val,
  output logic [IA_W-1:0]   reg_addr,
  output logic [IA_W-1:0]   ptr_addr
);

  localparam int SLOT_W = BANK_W + RSEL_W;
  localparam int PAD_W  = IA_W - SLOT_W;

  function automatic logic [IA_W-1:0] f_slot(logic [BANK_W-1:0] b, logic [RSEL_W-1:0] r);
    logic [SLOT_W-1:0] s;
    s = {b, r};
    return {{PAD_W{1'b0}}, s};
  endfunction

  assign reg_addr = f_slot(bank_sel, reg_sel);
  assign ptr_addr = reg_sel[0] ? r1_val : r0_val;

endmodule

// File: rtl/opaddr_sp_reg.sv
module opaddr_sp_reg #(
  parameter int              IA_W    = 8,
  parameter logic [IA_W-1:0] SP_INIT = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic            push_w,
  output logic            pop_w,
  output logic [IA_W-1:0] sp_q,
  output logic [IA_W-1:0] slot_addr
);

  logic [IA_W-1:0] sp_inc;
  logic [IA_W-1:0] sp_dec;

  assign push_w = push & ~pop;
  assign pop_w  = pop & ~push;
  assign sp_inc = sp_q + IA_W'(1);
  assign sp_dec = sp_q - IA_W'(1);

  // Pre-increment on push; post-decrement on pop, so pop reads the current slot.
  assign slot_addr = push_w ? sp_inc : sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= SP_INIT;
    else if (push_w) sp_q <= sp_inc;
    else if (pop_w)  sp_q <= sp_dec;
  end

endmodule

// File: rtl/opaddr_wide_sum.sv
module opaddr_wide_sum #(
  parameter int IA_W = 8,
  parameter int WA_W = 16
) (
  input  logic [WA_W-1:0] base,
  input  logic [IA_W-1:0] offs,
  output logic [WA_W-1:0] sum
);

  function automatic logic [WA_W-1:0] f_index(logic [WA_W-1:0] b, logic [IA_W-1:0] o);
    return b + {{(WA_W-IA_W){1'b0}}, o};
  endfunction

  assign sum = f_index(base, offs);

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int              IA_W    = OA_IA_W,
  parameter int              WA_W    = OA_WA_W,
  parameter int              RSEL_W  = 3,
  parameter int              BANK_W  = 2,
  parameter logic [IA_W-1:0] SP_INIT = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        mode,
  input  logic [RSEL_W-1:0] reg_sel,
  input  logic [IA_W-1:0]   dir_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [IA_W-1:0]   r0_val,
  input  logic [IA_W-1:0]   r1_val,
  input  logic [WA_W-1:0]   dptr,
  input  logic [WA_W-1:0]   pc,
  input  logic [IA_W-1:0]   acc,
  input  logic              push,
  input  logic              pop,
  output logic [WA_W-1:0]   addr_o,
  output logic [1:0]        space_o,
  output logic              valid_o,
  output logic [IA_W-1:0]   sp_o
);

  localparam int PAD_W = WA_W - IA_W;
  localparam int N_IDX = 2;

  logic [IA_W-1:0] reg_addr;
  logic [IA_W-1:0] ptr_addr;
  logic [IA_W-1:0] slot_addr;
  logic [IA_W-1:0] sp_q;
  logic            push_w;
  logic            pop_w;
  logic            stack_op_w;
  logic            req_ok_w;
  logic [WA_W-1:0] idx_base [N_IDX];
  logic [WA_W-1:0] idx_sum  [N_IDX];

  logic [WA_W-1:0] addr_d;
  oa_space_e       space_d;
  logic            valid_d;

  function automatic logic [WA_W-1:0] f_zext(logic [IA_W-1:0] a);
    return {{PAD_W{1'b0}}, a};
  endfunction

  function automatic oa_space_e f_dir_space(logic [IA_W-1:0] a);
    return a[IA_W-1] ? SPC_SFR : SPC_IRAM;
  endfunction

  opaddr_bank_map #(
    .IA_W  (IA_W),
    .RSEL_W(RSEL_W),
    .BANK_W(BANK_W)
  ) u_bank (
    .bank_sel(bank_sel),
    .reg_sel (reg_sel),
    .r0_val  (r0_val),
    .r1_val  (r1_val),
    .reg_addr(reg_addr),
    .ptr_addr(ptr_addr)
  );

  opaddr_sp_reg #(
    .IA_W   (IA_W),
    .SP_INIT(SP_INIT)
  ) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .push_w   (push_w),
    .pop_w    (pop_w),
    .sp_q     (sp_q),
    .slot_addr(slot_addr)
  );

  assign idx_base[0] = dptr;
  assign idx_base[1] = pc;

  for (genvar gi = 0; gi < N_IDX; gi++) begin : g_idx
    opaddr_wide_sum #(
      .IA_W(IA_W),
      .WA_W(WA_W)
    ) u_sum (
      .base(idx_base[gi]),
      .offs(acc),
      .sum (idx_sum[gi])
    );
  end

  assign stack_op_w = push_w | pop_w;
  assign req_ok_w   = req & (oa_mode_e'(mode) != MD_NONE);

  always_comb begin
    addr_d  = '0;
    space_d = SPC_IRAM;
    valid_d = stack_op_w | req_ok_w;
    if (stack_op_w) begin
      addr_d  = f_zext(slot_addr);
      space_d = SPC_IRAM;
    end else begin
      unique case (oa_mode_e'(mode))
        MD_DIRECT: begin
          addr_d  = f_zext(dir_addr);
          space_d = f_dir_space(dir_addr);
        end
        MD_REG: begin
          addr_d  = f_zext(reg_addr);
          space_d = SPC_IRAM;
        end
        MD_IND_PTR: begin
          addr_d  = f_zext(ptr_addr);
          space_d = SPC_IRAM;
        end
        MD_IND_SP: begin
          addr_d  = f_zext(sp_q);
          space_d = SPC_IRAM;
        end
        MD_XDATA: begin
          addr_d  = dptr;
          space_d = SPC_XRAM;
        end
        MD_IDX_DP: begin
          addr_d  = idx_sum[0];
          space_d = SPC_CODE;
        end
        MD_IDX_PC: begin
          addr_d  = idx_sum[1];
          space_d = SPC_CODE;
        end
        default: begin
          addr_d  = '0;
          space_d = SPC_IRAM;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      space_o <= SPC_IRAM;
      valid_o <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      space_o <= space_d;
      valid_o <= valid_d;
    end
  end

  assign sp_o = sp_q;

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk
  import opaddr_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req,
  input logic [2:0]            mode,
  input logic [OA_IA_W-1:0]    dir_addr,
  input logic [OA_WA_W-1:0]    dptr,
  input logic                  push_w,
  input logic                  pop_w,
  input logic [OA_WA_W-1:0]    addr_o,
  input logic [1:0]            space_o,
  input logic                  valid_o,
  input logic [OA_IA_W-1:0]    sp_o
);

  // R9
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_w |=> (OA_IA_W'(sp_o - $past(sp_o)) == OA_IA_W'(1)));

  // R9
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_w |=> (valid_o && addr_o == {8'h00, sp_o} && space_o == SPC_IRAM));

  // R10
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_w |=> (OA_IA_W'($past(sp_o) - sp_o) == OA_IA_W'(1)));

  // R10
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_w |=> (valid_o && addr_o[OA_IA_W-1:0] == $past(sp_o) && space_o == SPC_IRAM));

  // R11
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_w && !pop_w) |=> $stable(sp_o));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_w && !pop_w && (!req || mode == 3'd7)) |=> !valid_o);

  // R2
  dir_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd0 && !push_w && !pop_w) |=>
      (space_o == ($past(dir_addr[OA_IA_W-1]) ? SPC_SFR : SPC_IRAM)));

  // R6
  xdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == 3'd4 && !push_w && !pop_w) |=>
      (addr_o == $past(dptr) && space_o == SPC_XRAM));

endmodule

bind opaddr_gen opaddr_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .mode    (mode),
  .dir_addr(dir_addr),
  .dptr    (dptr),
  .push_w  (push_w),
  .pop_w   (pop_w),
  .addr_o  (addr_o),
  .space_o (space_o),
  .valid_o (valid_o),
  .sp_o    (sp_o)
);

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [2:0]  mode;
  logic [2:0]  reg_sel;
  logic [7:0]  dir_addr;
  logic [1:0]  bank_sel;
  logic [7:0]  r0_val;
  logic [7:0]  r1_val;
  logic [15:0] dptr;
  logic [15:0] pc;
  logic [7:0]  acc;
  logic        push;
  logic        pop;
  logic [15:0] addr_o;
  logic [1:0]  space_o;
  logic        valid_o;
  logic [7:0]  sp_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  opaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .reg_sel(reg_sel),
    .dir_addr(dir_addr), .bank_sel(bank_sel), .r0_val(r0_val), .r1_val(r1_val),
    .dptr(dptr), .pc(pc), .acc(acc), .push(push), .pop(pop),
    .addr_o(addr_o), .space_o(space_o), .valid_o(valid_o), .sp_o(sp_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs are applied just after a falling edge; the rising edge registers them,
  // and the result is sampled at the following falling edge.
  task automatic issue(logic r, logic [2:0] m, logic ps, logic pp);
    req = r; mode = m; push = ps; pop = pp;
    @(negedge clk);
  endtask

  task automatic expect_out(string tag, logic [15:0] a, logic [1:0] s);
    check({tag, " valid"}, valid_o, 1'b1);
    check({tag, " addr"}, addr_o, a);
    check({tag, " space"}, space_o, s);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 0; mode = 0; push = 0; pop = 0; reg_sel = 0;
    dir_addr = 0; bank_sel = 0; r0_val = 0; r1_val = 0; dptr = 0; pc = 0; acc = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", valid_o, 1'b0);
    check("R1 sp in reset", sp_o, 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", valid_o, 1'b0);
    check("R1 sp after reset", sp_o, 8'h07);
  endtask

  task automatic t_direct();
    dir_addr = 8'h7F; issue(1, 3'd0, 0, 0);
    expect_out("R2 direct 7F", 16'h007F, 2'd0);
    dir_addr = 8'h80; issue(1, 3'd0, 0, 0);
    expect_out("R2 direct 80", 16'h0080, 2'd1);
    dir_addr = 8'hE0; issue(1, 3'd0, 0, 0);
    expect_out("R2 direct E0", 16'h00E0, 2'd1);
  endtask

  task automatic t_register();
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b); reg_sel = 3'(7 - b);
      issue(1, 3'd1, 0, 0);
      expect_out("R3 register", 16'(b * 8 + (7 - b)), 2'd0);
    end
  endtask

  task automatic t_ind_ptr();
    r0_val = 8'h35; r1_val = 8'hC2;
    reg_sel = 3'd0; issue(1, 3'd2, 0, 0);
    expect_out("R4 via R0", 16'h0035, 2'd0);
    reg_sel = 3'd1; issue(1, 3'd2, 0, 0);
    expect_out("R4 via R1 upper", 16'h00C2, 2'd0);
  endtask

  task automatic t_ind_sp();
    issue(1, 3'd3, 0, 0);
    expect_out("R5 stack indirect", 16'h0007, 2'd0);
    check("R5 sp held", sp_o, 8'h07);
  endtask

  task automatic t_xdata();
    dptr = 16'hBEEF; issue(1, 3'd4, 0, 0);
    expect_out("R6 external", 16'hBEEF, 2'd2);
  endtask

  task automatic t_index();
    logic [16:0] full;
    dptr = 16'h1200; acc = 8'h34; issue(1, 3'd5, 0, 0);
    expect_out("R7 table index", 16'h1234, 2'd3);
    dptr = 16'hFFF0; acc = 8'hF0; issue(1, 3'd5, 0, 0);
    full = 17'(dptr) + 17'(acc);
    expect_out("R7 table wrap", full[15:0], 2'd3);
    pc = 16'hFF80; acc = 8'hFF; issue(1, 3'd6, 0, 0);
    full = 17'(pc) + 17'(acc);
    expect_out("R8 pc index wrap", full[15:0], 2'd3);
  endtask

  task automatic t_push_pop();
    issue(0, 3'd0, 1, 0);
    expect_out("R9 push addr", 16'h0008, 2'd0);
    check("R9 push sp", sp_o, 8'h08);
    issue(0, 3'd0, 0, 1);
    expect_out("R10 pop addr", 16'h0008, 2'd0);
    check("R10 pop sp", sp_o, 8'h07);
    for (int i = 0; i < 8; i++) issue(0, 3'd0, 0, 1);
    check("R10 pop wrap sp", sp_o, 8'hFF);
    check("R10 pop wrap addr", addr_o, 16'h0000);
    issue(0, 3'd0, 1, 0);
    expect_out("R9 push wrap", 16'h0000, 2'd0);
    check("R9 push wrap sp", sp_o, 8'h00);
    for (int i = 0; i < 7; i++) issue(0, 3'd0, 1, 0);
    check("R9 sp restored", sp_o, 8'h07);
  endtask

  task automatic t_priority();
    dptr = 16'h4321;
    issue(1, 3'd4, 1, 0);
    expect_out("R11 push overrides mode", 16'h0008, 2'd0);
    issue(1, 3'd4, 0, 1);
    expect_out("R11 pop overrides mode", 16'h0008, 2'd0);
    issue(1, 3'd4, 1, 1);
    expect_out("R11 both strobes serve request", 16'h4321, 2'd2);
    check("R11 both strobes sp held", sp_o, 8'h07);
  endtask

  task automatic t_idle();
    issue(1, 3'd7, 0, 0);
    check("R12 reserved mode", valid_o, 1'b0);
    issue(0, 3'd1, 0, 0);
    check("R12 no request", valid_o, 1'b0);
    check("R12 sp untouched", sp_o, 8'h07);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_register();
    t_ind_ptr();
    t_ind_sp();
    t_xdata();
    t_index();
    t_push_pop();
    t_priority();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule